// File: doc/BRIEF.md
# Random Bitstream Health Monitor

This block watches a raw random bit stream as it arrives, one bit per `bit_vld` strobe. It runs three statistical tests over fixed windows of `WIN_BITS` bits: a ones count, a count of each 4-bit pattern together with a sum-of-squares statistic, and a count of runs sorted by length. Every window starts from zero counters whatever the result of the previous one. Alongside the windows, two continuous detectors track how many identical bits have arrived in a row. A third continuous detector compares each assembled output word, strobed by `word_vld`, with the word strobed before it.

Each test drives its own sticky failure flag. A flag stays set until `flag_clr` is asserted. Whenever one or more flags go from clear to set, the block emits a one-cycle `alarm` pulse. A supervisor can take the alarm as an event and read the flags to find out which test tripped. The asynchronous reset is released through a two-stage synchronizer inside the block.

Top module: `rng_health_mon`

## Requirements
- R1: After reset, `fail_flags` is 0 and `alarm` is 0.
- R2: Flag bit 0 (monobit) is set when the number of ones in a window is below `MONO_LO` or above `MONO_HI`.
- R3: Flag bit 1 (poker) is set at the end of a window when either of two conditions holds. The window is cut into 4-bit groups, and the first-received bit of each group is its MSB. The first condition is that some group value occurs fewer than `POK_CNT_LO` or more than `POK_CNT_HI` times. The second is that S = 16·Σcount² − N² (N = `WIN_BITS`/4) is not strictly greater than `POK_LO_S` and strictly less than `POK_HI_S`.
- R4: Flag bit 2 (runs) is set when any run-length class count in a window falls outside its bounds. Runs are maximal groups of equal bits, and a run never spans two windows. Classes 1 to `RCLS`−1 count runs of exactly that length, and class `RCLS` counts runs of length `RCLS` or longer. The run still open at the end of a window is counted. Class k has bounds [`RUN_LO1`>>(k−1), `RUN_HI1`>>(k−1)].
- R5: Only cycles with `bit_vld` high advance the window. After `WIN_BITS` valid bits the window is evaluated and all window counters restart from zero, even when a test has failed.
- R6: Flag bit 3 (long run) is set on the valid bit that completes `LONG_RUN` identical consecutive valid bits, counted across window boundaries.
- R7: Flag bit 4 (noise) is set on the valid bit that completes `NOISE_RUN` identical consecutive valid bits.
- R8: Flag bit 5 (stuck) is set when a `word_vld` word equals the previous `word_vld` word.
- R9: Flags stay set until `flag_clr`. A failure event in the same cycle as `flag_clr` leaves its flag set.
- R10: `alarm` is high for exactly the one cycle after an event cycle in which at least one flag went from clear to set, and it is low otherwise. Flags update one clock after the strobe that caused the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Raw bit strobe |
| bit_in | input | 1 | Raw bit value |
| word_vld | input | 1 | Output word strobe |
| word_in | input | WORD_W | Assembled output word |
| flag_clr | input | 1 | Clears all failure flags |
| fail_flags | output | 6 | Sticky flags: 0 monobit, 1 poker, 2 runs, 3 long run, 4 noise, 5 stuck |
| alarm | output | 1 | One-cycle pulse on a newly set flag |

## Verification
The bench builds the block with a 16-bit window (four groups), `RCLS`=3, run bounds [2,8], monobit bounds [6,10], group counts at most 2, S bounds 48 and 112, `LONG_RUN`=5, `NOISE_RUN`=8 and 8-bit words. With these values every poker statistic (48, 80, 112, 144, 240) and every run class sits close to a pass/fail edge. The bench feeds thousands of distinct windows, and some of them contain idle gaps. It also sends runs of equal bits that cross window boundaries and repeated words mixed with clears. These cases exercise pass and fail on each bound, a flag that is set again while already set, and the case where a set meets a clear in the same cycle.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
  localparam int NFLAGS    = 6;
  localparam int FLG_MONO  = 0;
  localparam int FLG_POKER = 1;
  localparam int FLG_RUNS  = 2;
  localparam int FLG_LONG  = 3;
  localparam int FLG_NOISE = 4;
  localparam int FLG_STUCK = 5;
  typedef logic [NFLAGS-1:0] flags_t;
endpackage

// File: rtl/rhm_window.sv
module rhm_window #(
  parameter int WIN_BITS   = 20000,
  parameter int MONO_LO    = 9725,
  parameter int MONO_HI    = 10275,
  parameter int POK_CNT_LO = 220,
  parameter int POK_CNT_HI = 410,
  parameter int POK_LO_S   = 10800,
  parameter int POK_HI_S   = 230850,
  parameter int RCLS       = 6,
  parameter int RUN_LO1    = 4600,
  parameter int RUN_HI1    = 5400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic mono_ev,
  output logic poker_ev,
  output logic runs_ev
);
  localparam int CW  = $clog2(WIN_BITS + 1);
  localparam int NIB = WIN_BITS / 4;
  localparam int SW  = $clog2(NIB * NIB + 1) + 1;
  localparam int LW  = $clog2(RCLS + 2);

  logic [CW-1:0] bit_cnt_q, ones_q, ones_d;
  logic [2:0]    nib_q;
  logic [CW-1:0] pk_q [16];
  logic [CW-1:0] pk_d [16];
  logic [SW-1:0] sq_q, sq_d;
  logic [LW-1:0] rl_q, rl_d, rl_inc;
  logic          prev_q;
  logic [CW-1:0] rc_q [RCLS];
  logic [CW-1:0] rc_d [RCLS];
  logic          first, last, nib_done, same, close_old;
  logic [3:0]    nib_val;
  logic          pk_bad;
  logic [RCLS-1:0] rc_bad;
  int            stat;

  // next-state logic
  always_comb begin
    first     = (bit_cnt_q == '0);
    last      = (bit_cnt_q == CW'(WIN_BITS - 1));
    nib_done  = (bit_cnt_q[1:0] == 2'b11);
    nib_val   = {nib_q, bit_in};
    same      = !first && (bit_in == prev_q);
    close_old = !first && (bit_in != prev_q);
    rl_inc    = (rl_q == LW'(RCLS)) ? rl_q : rl_q + 1'b1;
    rl_d      = same ? rl_inc : LW'(1);
    ones_d    = ones_q + CW'(bit_in);
    sq_d      = sq_q;
    for (int k = 0; k < 16; k++) begin
      pk_d[k] = pk_q[k];
      if (nib_done && nib_val == 4'(k)) begin
        pk_d[k] = pk_q[k] + 1'b1;
        sq_d    = sq_q + SW'({pk_q[k], 1'b1});   // (c+1)^2 - c^2 = 2c+1
      end
    end
    for (int j = 0; j < RCLS; j++) begin
      rc_d[j] = rc_q[j] + CW'(close_old && rl_q == LW'(j + 1))
                        + CW'(last && rl_d == LW'(j + 1));
    end
    stat   = 16 * int'(sq_d) - NIB * NIB;
    pk_bad = (stat <= POK_LO_S) || (stat >= POK_HI_S);
    for (int k = 0; k < 16; k++) begin
      if (int'(pk_d[k]) < POK_CNT_LO || int'(pk_d[k]) > POK_CNT_HI) pk_bad = 1'b1;
    end
    for (int j = 0; j < RCLS; j++) begin
      rc_bad[j] = (int'(rc_d[j]) < (RUN_LO1 >> j)) || (int'(rc_d[j]) > (RUN_HI1 >> j));
    end
    mono_ev  = bit_vld && last && (int'(ones_d) < MONO_LO || int'(ones_d) > MONO_HI);
    poker_ev = bit_vld && last && pk_bad;
    runs_ev  = bit_vld && last && (|rc_bad);
  end

  // registers, enabled by the bit strobe; cleared at window end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      ones_q    <= '0;
      nib_q     <= '0;
      sq_q      <= '0;
      rl_q      <= '0;
      prev_q    <= 1'b0;
      for (int k = 0; k < 16; k++) pk_q[k] <= '0;
      for (int j = 0; j < RCLS; j++) rc_q[j] <= '0;
    end else if (bit_vld) begin
      if (last) begin
        bit_cnt_q <= '0;
        ones_q    <= '0;
        nib_q     <= '0;
        sq_q      <= '0;
        rl_q      <= '0;
        prev_q    <= 1'b0;
        for (int k = 0; k < 16; k++) pk_q[k] <= '0;
        for (int j = 0; j < RCLS; j++) rc_q[j] <= '0;
      end else begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        ones_q    <= ones_d;
        nib_q     <= {nib_q[1:0], bit_in};
        sq_q      <= sq_d;
        rl_q      <= rl_d;
        prev_q    <= bit_in;
        for (int k = 0; k < 16; k++) pk_q[k] <= pk_d[k];
        for (int j = 0; j < RCLS; j++) rc_q[j] <= rc_d[j];
      end
    end
  end

  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && last) |=> (bit_cnt_q == '0 && ones_q == '0 && sq_q == '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(bit_cnt_q) && $stable(ones_q)); // R5
  AST_ONES_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= bit_cnt_q); // R2
  AST_EVENT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mono_ev || poker_ev || runs_ev) |-> (bit_vld && bit_cnt_q == CW'(WIN_BITS - 1))); // R4
endmodule

// File: rtl/rhm_repeat.sv
module rhm_repeat #(
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic long_ev,
  output logic noise_ev
);
  localparam int RW = $clog2(NOISE_RUN + 1);

  logic [RW-1:0] len_q, len_d;
  logic          have_q, prev_q;

  always_comb begin
    if (!have_q || bit_in != prev_q) len_d = RW'(1);
    else if (len_q == RW'(NOISE_RUN)) len_d = len_q;
    else len_d = len_q + 1'b1;
    long_ev  = bit_vld && (len_d == RW'(LONG_RUN)) && (len_q != RW'(LONG_RUN) || !have_q || bit_in != prev_q);
    noise_ev = bit_vld && (len_d == RW'(NOISE_RUN)) && (len_q != RW'(NOISE_RUN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      have_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (bit_vld) begin
      len_q  <= len_d;
      have_q <= 1'b1;
      prev_q <= bit_in;
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    have_q |-> (len_q != '0)); // R6
  AST_NOISE_AFTER_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    noise_ev |-> (int'(len_q) >= LONG_RUN)); // R7
endmodule

// File: rtl/rhm_stuck.sv
module rhm_stuck #(
  parameter int WORD_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output logic              stuck_ev
);
  logic [WORD_W-1:0] last_q;
  logic              have_q;

  always_comb stuck_ev = word_vld && have_q && (word_in == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      have_q <= 1'b0;
    end else if (word_vld) begin
      last_q <= word_in;
      have_q <= 1'b1;
    end
  end

  AST_STUCK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_ev |-> (word_vld && $past(word_vld) | have_q)); // R8
endmodule

// File: rtl/rhm_flags.sv
module rhm_flags
  import rhm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t ev,
  input  logic   clr,
  output flags_t flags,
  output logic   alarm
);
  flags_t flags_d;
  logic   alarm_d;

  always_comb begin
    flags_d = (clr ? '0 : flags) | ev;
    alarm_d = |(ev & ~flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      alarm <= 1'b0;
    end else begin
      flags <= flags_d;
      alarm <= alarm_d;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> ((flags & $past(flags)) == $past(flags))); // R9
  AST_ALARM_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> ((flags & ~$past(flags)) != '0)); // R10
endmodule

// File: rtl/rng_health_mon.sv
module rng_health_mon
  import rhm_pkg::*;
#(
  parameter int WIN_BITS   = 20000,
  parameter int MONO_LO    = 9725,
  parameter int MONO_HI    = 10275,
  parameter int POK_CNT_LO = 220,
  parameter int POK_CNT_HI = 410,
  parameter int POK_LO_S   = 10800,
  parameter int POK_HI_S   = 230850,
  parameter int RCLS       = 6,
  parameter int RUN_LO1    = 4600,
  parameter int RUN_HI1    = 5400,
  parameter int LONG_RUN   = 34,
  parameter int NOISE_RUN  = 48,
  parameter int WORD_W     = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  input  logic              flag_clr,
  output logic [5:0]        fail_flags,
  output logic              alarm
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  flags_t     ev;
  flags_t     flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rhm_window #(
    .WIN_BITS(WIN_BITS), .MONO_LO(MONO_LO), .MONO_HI(MONO_HI),
    .POK_CNT_LO(POK_CNT_LO), .POK_CNT_HI(POK_CNT_HI),
    .POK_LO_S(POK_LO_S), .POK_HI_S(POK_HI_S),
    .RCLS(RCLS), .RUN_LO1(RUN_LO1), .RUN_HI1(RUN_HI1)
  ) u_window (
    .clk(clk), .rst_n(rst_n_s), .bit_vld(bit_vld), .bit_in(bit_in),
    .mono_ev(ev[FLG_MONO]), .poker_ev(ev[FLG_POKER]), .runs_ev(ev[FLG_RUNS])
  );

  rhm_repeat #(.LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_repeat (
    .clk(clk), .rst_n(rst_n_s), .bit_vld(bit_vld), .bit_in(bit_in),
    .long_ev(ev[FLG_LONG]), .noise_ev(ev[FLG_NOISE])
  );

  rhm_stuck #(.WORD_W(WORD_W)) u_stuck (
    .clk(clk), .rst_n(rst_n_s), .word_vld(word_vld), .word_in(word_in),
    .stuck_ev(ev[FLG_STUCK])
  );

  rhm_flags u_flags (
    .clk(clk), .rst_n(rst_n_s), .ev(ev), .clr(flag_clr),
    .flags(flags), .alarm(alarm)
  );

  assign fail_flags = flags;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (fail_flags == '0 && !alarm)); // R1
endmodule

// File: tb/tb_rng_health_mon.sv
`timescale 1ns/100ps
module tb_rng_health_mon;
  localparam int WB = 16, MLO = 6, MHI = 10, PCL = 0, PCH = 2, PLS = 48, PHS = 112;
  localparam int RC = 3, RL1 = 2, RH1 = 8, LR = 5, NR = 8, WW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 0, bit_in = 0, word_vld = 0, flag_clr = 0;
  logic [WW-1:0] word_in = '0;
  logic [5:0] fail_flags;
  logic alarm;

  always #2.5 clk = ~clk;

  rng_health_mon #(
    .WIN_BITS(WB), .MONO_LO(MLO), .MONO_HI(MHI), .POK_CNT_LO(PCL), .POK_CNT_HI(PCH),
    .POK_LO_S(PLS), .POK_HI_S(PHS), .RCLS(RC), .RUN_LO1(RL1), .RUN_HI1(RH1),
    .LONG_RUN(LR), .NOISE_RUN(NR), .WORD_W(WW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .word_vld(word_vld), .word_in(word_in), .flag_clr(flag_clr),
    .fail_flags(fail_flags), .alarm(alarm)
  );

  int n_chk = 0, n_bad = 0;
  logic [5:0] exp_flags = '0;
  logic exp_alarm = 0;
  int rlen = 0; logic have_b = 0, prev_b = 0;
  logic [15:0] win_pat = '0; int wpos = 0;
  logic have_w = 0; logic [WW-1:0] last_w = '0;
  string tag [6] = '{"R2", "R3", "R4", "R6", "R7", "R8"};

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [2:0] win_eval(input logic [15:0] w);
    int c [16]; int r [4]; int ones, sq, st, len; logic [2:0] f;
    for (int k = 0; k < 16; k++) c[k] = 0;
    for (int k = 0; k < 4; k++) r[k] = 0;
    ones = $countones(w);
    f[0] = (ones < MLO) || (ones > MHI);
    for (int n = 0; n < 4; n++) c[w[15-4*n -: 4]]++;
    sq = 0; f[1] = 0;
    for (int k = 0; k < 16; k++) begin
      sq += c[k] * c[k];
      if (c[k] < PCL || c[k] > PCH) f[1] = 1;
    end
    st = 16 * sq - 16;
    if (st <= PLS || st >= PHS) f[1] = 1;
    len = 1;
    for (int j = 14; j >= -1; j--) begin
      if (j >= 0 && w[j] == w[j+1]) len++;
      else begin r[(len > RC) ? RC : len]++; len = 1; end
    end
    f[2] = 0;
    for (int k = 1; k <= RC; k++)
      if (r[k] < (RL1 >> (k-1)) || r[k] > (RH1 >> (k-1))) f[2] = 1;
    return f;
  endfunction

  task automatic step(input logic v, input logic b, input logic wv,
                      input logic [WW-1:0] w, input logic c);
    logic [5:0] ev = '0;
    bit_vld = v; bit_in = b; word_vld = wv; word_in = w; flag_clr = c;
    if (v) begin
      if (have_b && b == prev_b) rlen++; else rlen = 1;
      have_b = 1; prev_b = b;
      if (rlen == LR) ev[3] = 1;
      if (rlen == NR) ev[4] = 1;
      win_pat = {win_pat[14:0], b}; wpos++;
      if (wpos == WB) begin ev[2:0] = win_eval(win_pat); wpos = 0; end
    end
    if (wv) begin
      if (have_w && w == last_w) ev[5] = 1;
      have_w = 1; last_w = w;
    end
    exp_alarm = |(ev & ~exp_flags);
    exp_flags = (c ? 6'd0 : exp_flags) | ev;
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < 6; i++) check(tag[i], int'(fail_flags[i]), int'(exp_flags[i]));
    check("R10", int'(alarm), int'(exp_alarm));
  endtask

  task automatic send_win(input logic [15:0] p, input logic gaps,
                          input logic wv, input logic [WW-1:0] w);
    for (int j = 15; j >= 0; j--) begin
      step(1'b1, p[j], (j == 15) && wv, w, 1'b0);
      if (gaps && (j % 3 == 0)) step(1'b0, ~p[j], 1'b0, '0, 1'b0);
    end
  endtask

  task automatic do_clr();
    step(1'b0, 1'b0, 1'b0, '0, 1'b1);
    check("R9", int'(fail_flags), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(fail_flags), 0);
    check("R1", int'(alarm), 0);
    // directed windows: alternating, all zeros across windows, all ones
    send_win(16'hAAAA, 0, 1, 8'h11); do_clr();
    send_win(16'h0000, 0, 0, '0);  // R6 R7 inside window
    send_win(16'h0000, 0, 0, '0);
    do_clr();
    send_win(16'h03C0, 0, 0, '0); send_win(16'hFFFF, 0, 0, '0); do_clr();
    send_win(16'h1B2D, 0, 0, '0); send_win(16'h4E87, 1, 0, '0); do_clr();
    // R5: window with idle gaps still evaluates monobit on valid bits only
    send_win(16'hF7FF, 1, 0, '0);
    check("R5", int'(fail_flags[0]), 1);
    do_clr();
    // R9: set beats clear in the same cycle
    step(1'b0, 1'b0, 1'b1, 8'h5A, 1'b0);
    step(1'b0, 1'b0, 1'b1, 8'h5A, 1'b1);
    check("R9", int'(fail_flags[5]), 1);
    do_clr();
    // sweep of many windows with words, gaps and periodic clears
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] p = 16'((i * 40503 + 12345) & 16'hFFFF);
      logic [WW-1:0] w = (i % 5 == 0) ? last_w : WW'(i * 7);
      send_win(p, (i % 7 == 3), (i % 2 == 0), w);
      if (i % 8 == 7) do_clr();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule